// File: doc/BRIEF.md
# RV32I Integer ALU with Instruction-Field Decode

This block computes the result of the base 32-bit integer arithmetic, logic, shift and compare operations. It picks the operation from the opcode, funct3 and funct7 fields of an instruction word. It is purely combinational. The surrounding datapath slices the fields out of the instruction and feeds them in, together with four data inputs:

- the first operand;
- the second operand, which is either a register value or an immediate that the caller has already sign-extended;
- the 20-bit upper immediate;
- the program counter.

The block covers both instruction forms. The register-register form supports subtract and arithmetic right shift, selected by funct7 bit 5. In the register-immediate form, funct7 holds immediate bits, and that bit only has meaning for the right-shift variants. The block also produces the results of the two upper-immediate instructions, load-upper and add-upper-to-PC.

Any field combination outside the supported set raises `illegal_o` and forces the result to zero. That combination may be an unknown opcode, a funct7 value the base integer set does not define, or a malformed immediate shift. Because there is no storage, there is no clock, no reset and no back-pressure. The result is valid in the same cycle as its inputs, and the caller registers it.

Top module: `rv32_int_alu`

## Requirements
- R1: With opcode 0110011 (register form) and funct7 0000000, or opcode 0010011 (immediate form), funct3 000 yields operand A plus operand B, modulo 2^32.
- R2: Subtract (A minus B, modulo 2^32) is produced only for opcode 0110011 with funct3 000 and funct7 0100000. For opcode 0010011 with funct3 000, the result is always A plus B, whatever the funct7 bits are.
- R3: funct3 010 yields 1 when A is less than B as signed two's-complement values, and 0 otherwise, in both forms.
- R4: funct3 011 yields 1 when A is less than B as unsigned values, and 0 otherwise, in both forms.
- R5: funct3 100, 110 and 111 yield the bitwise XOR, OR and AND of A and B, in both forms.
- R6: funct3 001 shifts A left, filling with zeros. The shift amount is bits [4:0] of operand B, and the higher bits of B are ignored.
- R7: funct3 101 with funct7 0000000 shifts A right and fills with zeros. With funct7 0100000 it shifts A right and fills with copies of A[31]. Both cases use B[4:0] as the amount and apply to both forms.
- R8: Opcode 0110111 yields the upper immediate in result bits [31:12] and zeros in bits [11:0]. The operands, funct3 and funct7 have no effect.
- R9: Opcode 0010111 yields the PC plus the upper immediate placed in bits [31:12], with bits [11:0] zero, modulo 2^32.
- R10: `illegal_o` is 1 and the result is 0 in each of these cases:
  - the opcode is none of 0110011, 0010011, 0110111 and 0010111;
  - the register form has a funct7 other than 0000000, except 0100000 with funct3 000 or 101;
  - the immediate form with funct3 001 has a funct7 other than 0000000;
  - the immediate form with funct3 101 has a funct7 other than 0000000 or 0100000.
- R11: `illegal_o` is 0 for every combination that R1 to R9 define.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode_i | input | 7 | Instruction bits [6:0] |
| funct3_i | input | 3 | Instruction bits [14:12] |
| funct7_i | input | 7 | Instruction bits [31:25] |
| upper_imm_i | input | 20 | Instruction bits [31:12], for the upper-immediate opcodes |
| pc_i | input | 32 | Address of the instruction |
| opnd_a_i | input | 32 | First operand (register value) |
| opnd_b_i | input | 32 | Second operand (register value or sign-extended immediate) |
| result_o | output | 32 | Operation result, zero when illegal |
| illegal_o | output | 1 | Unsupported field combination |

## Verification
The assertions check the following whenever the inputs change:

- an illegal flag always comes with a zero result;
- an unknown opcode is always flagged;
- the compare operations only ever return 0 or 1;
- a left shift clears its low bits;
- a logical right shift with a non-zero amount clears the top bit;
- load-upper passes its immediate through with a clear low half;
- the immediate add path never subtracts.

Only the bench's scenarios show the rest, because each needs chosen operand values and a known result:

- the sign boundary where the signed and unsigned compares disagree;
- arithmetic fill against logical fill;
- the upper bits of operand B being ignored as a shift amount;
- wrap-around in add, subtract and add-upper-to-PC;
- each separate reason a field combination is rejected.

// File: rtl/rv32_alu_pkg.sv
package rv32_alu_pkg;

  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;

  localparam logic [6:0] F7_BASE = 7'b0000000;
  localparam logic [6:0] F7_ALT  = 7'b0100000;

  typedef enum logic [3:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_SLL,
    ALU_SLT,
    ALU_SLTU,
    ALU_XOR,
    ALU_SRL,
    ALU_SRA,
    ALU_OR,
    ALU_AND,
    ALU_LUI,
    ALU_AUIPC,
    ALU_NONE
  } alu_op_e;

  // Base mapping of funct3 onto the operation, before funct7 qualification.
  function automatic alu_op_e f3_base_op(input logic [2:0] f3);
    case (f3)
      3'b000:  return ALU_ADD;
      3'b001:  return ALU_SLL;
      3'b010:  return ALU_SLT;
      3'b011:  return ALU_SLTU;
      3'b100:  return ALU_XOR;
      3'b101:  return ALU_SRL;
      3'b110:  return ALU_OR;
      default: return ALU_AND;
    endcase
  endfunction

endpackage

// File: rtl/rv32_alu_decode.sv
module rv32_alu_decode
  import rv32_alu_pkg::*;
(
  input  logic [6:0] opcode_i,
  input  logic [2:0] funct3_i,
  input  logic [6:0] funct7_i,
  output alu_op_e    op_o,
  output logic       illegal_o
);

  alu_op_e op_d;

  always_comb begin
    op_d = ALU_NONE;
    case (opcode_i)
      OPC_REG: begin
        if (funct7_i == F7_BASE) begin
          op_d = f3_base_op(funct3_i);
        end else if (funct7_i == F7_ALT) begin
          if (funct3_i == 3'b000)      op_d = ALU_SUB;
          else if (funct3_i == 3'b101) op_d = ALU_SRA;
        end
      end
      OPC_IMM: begin
        case (funct3_i)
          3'b001: if (funct7_i == F7_BASE) op_d = ALU_SLL;
          3'b101: begin
            if (funct7_i == F7_BASE)     op_d = ALU_SRL;
            else if (funct7_i == F7_ALT) op_d = ALU_SRA;
          end
          // funct7 holds immediate bits here; never selects subtract
          default: op_d = f3_base_op(funct3_i);
        endcase
      end
      OPC_LUI:   op_d = ALU_LUI;
      OPC_AUIPC: op_d = ALU_AUIPC;
      default:   op_d = ALU_NONE;
    endcase
  end

  assign op_o      = op_d;
  assign illegal_o = (op_d == ALU_NONE);

endmodule

// File: rtl/rv32_alu_shift.sv
module rv32_alu_shift
  import rv32_alu_pkg::*;
#(
  parameter int XLEN          = 32,
  parameter bit SHARE_SHIFTER = 1'b1,
  localparam int SHW          = $clog2(XLEN)
) (
  input  alu_op_e           op_i,
  input  logic [XLEN-1:0]   data_i,
  input  logic [SHW-1:0]    amt_i,
  output logic [XLEN-1:0]   sll_o,
  output logic [XLEN-1:0]   srl_o,
  output logic [XLEN-1:0]   sra_o
);

  generate
    if (SHARE_SHIFTER) begin : g_shared
      logic [XLEN-1:0] rev_in;
      logic [XLEN-1:0] src;
      logic [XLEN-1:0] shr;
      logic [XLEN-1:0] rev_out;
      logic            fill;

      always_comb begin
        for (int i = 0; i < XLEN; i++) rev_in[i] = data_i[XLEN-1-i];
      end

      assign src  = (op_i == ALU_SLL) ? rev_in : data_i;
      assign fill = (op_i == ALU_SRA) & data_i[XLEN-1];
      assign shr  = (src >> amt_i) | (fill ? ~({XLEN{1'b1}} >> amt_i) : '0);

      always_comb begin
        for (int i = 0; i < XLEN; i++) rev_out[i] = shr[XLEN-1-i];
      end

      assign sll_o = rev_out;
      assign srl_o = shr;
      assign sra_o = shr;
    end else begin : g_split
      logic unused_op;
      assign unused_op = ^op_i;
      assign sll_o = data_i << amt_i;
      assign srl_o = data_i >> amt_i;
      assign sra_o = $unsigned($signed(data_i) >>> amt_i);
    end
  endgenerate

endmodule

// File: rtl/rv32_alu_core.sv
module rv32_alu_core
  import rv32_alu_pkg::*;
#(
  parameter int XLEN          = 32,
  parameter bit SHARE_SHIFTER = 1'b1,
  localparam int SHW          = $clog2(XLEN)
) (
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] upper_i,
  output logic [XLEN-1:0] result_o
);

  logic            do_sub;
  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] sum;
  logic            lt_u;
  logic            lt_s;
  logic [XLEN-1:0] sll_r;
  logic [XLEN-1:0] srl_r;
  logic [XLEN-1:0] sra_r;

  assign do_sub = (op_i == ALU_SUB);
  assign b_eff  = do_sub ? ~b_i : b_i;
  assign sum    = a_i + b_eff + {{(XLEN-1){1'b0}}, do_sub};

  assign lt_u = (a_i < b_i);
  assign lt_s = (a_i[XLEN-1] != b_i[XLEN-1]) ? a_i[XLEN-1] : lt_u;

  rv32_alu_shift #(
    .XLEN          (XLEN),
    .SHARE_SHIFTER (SHARE_SHIFTER)
  ) shift_i (
    .op_i   (op_i),
    .data_i (a_i),
    .amt_i  (b_i[SHW-1:0]),
    .sll_o  (sll_r),
    .srl_o  (srl_r),
    .sra_o  (sra_r)
  );

  always_comb begin
    case (op_i)
      ALU_ADD, ALU_SUB: result_o = sum;
      ALU_SLL:          result_o = sll_r;
      ALU_SLT:          result_o = {{(XLEN-1){1'b0}}, lt_s};
      ALU_SLTU:         result_o = {{(XLEN-1){1'b0}}, lt_u};
      ALU_XOR:          result_o = a_i ^ b_i;
      ALU_SRL:          result_o = srl_r;
      ALU_SRA:          result_o = sra_r;
      ALU_OR:           result_o = a_i | b_i;
      ALU_AND:          result_o = a_i & b_i;
      ALU_LUI:          result_o = upper_i;
      ALU_AUIPC:        result_o = pc_i + upper_i;
      default:          result_o = '0;
    endcase
  end

endmodule

// File: rtl/rv32_int_alu.sv
module rv32_int_alu
  import rv32_alu_pkg::*;
#(
  parameter int XLEN          = 32,
  parameter bit SHARE_SHIFTER = 1'b1
) (
  input  logic [6:0]      opcode_i,
  input  logic [2:0]      funct3_i,
  input  logic [6:0]      funct7_i,
  input  logic [19:0]     upper_imm_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] opnd_a_i,
  input  logic [XLEN-1:0] opnd_b_i,
  output logic [XLEN-1:0] result_o,
  output logic            illegal_o
);

  localparam int LOW_W = XLEN - 20;

  alu_op_e         op;
  logic [XLEN-1:0] upper_word;

  assign upper_word = {upper_imm_i, {LOW_W{1'b0}}};

  rv32_alu_decode decode_i (
    .opcode_i  (opcode_i),
    .funct3_i  (funct3_i),
    .funct7_i  (funct7_i),
    .op_o      (op),
    .illegal_o (illegal_o)
  );

  rv32_alu_core #(
    .XLEN          (XLEN),
    .SHARE_SHIFTER (SHARE_SHIFTER)
  ) core_i (
    .op_i     (op),
    .a_i      (opnd_a_i),
    .b_i      (opnd_b_i),
    .pc_i     (pc_i),
    .upper_i  (upper_word),
    .result_o (result_o)
  );

endmodule

// File: rtl/rv32_int_alu_chk.sv
module rv32_int_alu_chk
  import rv32_alu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input logic [6:0]      opcode_i,
  input logic [2:0]      funct3_i,
  input logic [6:0]      funct7_i,
  input logic [19:0]     upper_imm_i,
  input logic [XLEN-1:0] opnd_a_i,
  input logic [XLEN-1:0] opnd_b_i,
  input logic [XLEN-1:0] result_o,
  input logic            illegal_o
);

  logic            known_opc;
  logic            arith_form;
  logic [4:0]      amt;
  logic [XLEN-1:0] low_mask;

  assign known_opc  = (opcode_i == OPC_REG) || (opcode_i == OPC_IMM) ||
                      (opcode_i == OPC_LUI) || (opcode_i == OPC_AUIPC);
  assign arith_form = (opcode_i == OPC_REG) || (opcode_i == OPC_IMM);
  assign amt        = opnd_b_i[4:0];
  assign low_mask   = ({{(XLEN-1){1'b0}}, 1'b1} << amt) - 1'b1;

  always_comb begin
    AST_ILLEGAL_ZERO: assert (!illegal_o || result_o == '0)
      else $error("illegal without zero result"); // R10
    AST_UNKNOWN_OPC: assert (known_opc || illegal_o)
      else $error("unknown opcode not flagged"); // R10
    AST_CMP_BOOL: assert (!(arith_form && !illegal_o &&
                            (funct3_i == 3'b010 || funct3_i == 3'b011)) ||
                          result_o[XLEN-1:1] == '0)
      else $error("compare result not boolean"); // R3
    AST_SLL_LOW_CLEAR: assert (!(arith_form && !illegal_o && funct3_i == 3'b001) ||
                               (result_o & low_mask) == '0)
      else $error("left shift low bits not clear"); // R6
    AST_SRL_TOP_CLEAR: assert (!(arith_form && !illegal_o && funct3_i == 3'b101 &&
                                 funct7_i == F7_BASE && amt != 5'd0) ||
                               !result_o[XLEN-1])
      else $error("logical right shift top bit set"); // R7
    AST_LUI_PASS: assert (opcode_i != OPC_LUI ||
                          (!illegal_o && result_o == {upper_imm_i, {(XLEN-20){1'b0}}}))
      else $error("load-upper result wrong"); // R8
    AST_IMM_NO_SUB: assert (!(opcode_i == OPC_IMM && funct3_i == 3'b000) ||
                            (!illegal_o && result_o == opnd_a_i + opnd_b_i))
      else $error("immediate add path wrong"); // R2
  end

endmodule

bind rv32_int_alu rv32_int_alu_chk #(.XLEN(XLEN)) chk_i (
  .opcode_i    (opcode_i),
  .funct3_i    (funct3_i),
  .funct7_i    (funct7_i),
  .upper_imm_i (upper_imm_i),
  .opnd_a_i    (opnd_a_i),
  .opnd_b_i    (opnd_b_i),
  .result_o    (result_o),
  .illegal_o   (illegal_o)
);

// File: tb/rv32_int_alu_tb_top.sv
`timescale 1ns/1ps
module rv32_int_alu_tb_top;

  localparam logic [6:0] REG = 7'b0110011;
  localparam logic [6:0] IMM = 7'b0010011;
  localparam logic [6:0] LUI = 7'b0110111;
  localparam logic [6:0] AUI = 7'b0010111;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  opcode = '0;
  logic [2:0]  funct3 = '0;
  logic [6:0]  funct7 = '0;
  logic [19:0] uimm = '0;
  logic [31:0] pc = '0;
  logic [31:0] opa = '0;
  logic [31:0] opb = '0;
  logic [31:0] result;
  logic        illegal;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  rv32_int_alu dut_i (
    .opcode_i    (opcode),
    .funct3_i    (funct3),
    .funct7_i    (funct7),
    .upper_imm_i (uimm),
    .pc_i        (pc),
    .opnd_a_i    (opa),
    .opnd_b_i    (opb),
    .result_o    (result),
    .illegal_o   (illegal)
  );

  task automatic drive(input logic [6:0] opc, input logic [2:0] f3, input logic [6:0] f7,
                       input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    opcode = opc; funct3 = f3; funct7 = f7; opa = a; opb = b;
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] exp_res, input logic exp_ill);
    n_checks++;
    if (result !== exp_res || illegal !== exp_ill) begin
      n_fails++;
      $display("FAIL %s: result=%h illegal=%b expected result=%h illegal=%b",
               req, result, illegal, exp_res, exp_ill);
    end
  endtask

  task automatic t_idle;
    drive(7'd0, 3'd0, 7'd0, 32'd0, 32'd0);
    check("R10 idle zero opcode", 32'd0, 1'b1);
  endtask

  task automatic t_add;
    drive(REG, 3'b000, 7'h00, 32'd5, 32'd7);
    check("R1 add", 32'd12, 1'b0);
    drive(REG, 3'b000, 7'h00, 32'hFFFF_FFFF, 32'd1);
    check("R1 add wrap", 32'd0, 1'b0);
    drive(IMM, 3'b000, 7'h7F, 32'd100, 32'hFFFF_FFF6);
    check("R1 addi negative imm", 32'd90, 1'b0);
  endtask

  task automatic t_sub;
    drive(REG, 3'b000, 7'h20, 32'd10, 32'd3);
    check("R2 sub", 32'd7, 1'b0);
    drive(REG, 3'b000, 7'h20, 32'd3, 32'd10);
    check("R2 sub wrap", 32'hFFFF_FFF9, 1'b0);
    drive(IMM, 3'b000, 7'h20, 32'd10, 32'h0000_0400);
    check("R2 addi with bit30 set adds", 32'h0000_040A, 1'b0);
  endtask

  task automatic t_compare;
    drive(REG, 3'b010, 7'h00, 32'hFFFF_FFFF, 32'd1);
    check("R3 slt negative", 32'd1, 1'b0);
    drive(REG, 3'b011, 7'h00, 32'hFFFF_FFFF, 32'd1);
    check("R4 sltu large", 32'd0, 1'b0);
    drive(IMM, 3'b010, 7'h7F, 32'd5, 32'hFFFF_FFFD);
    check("R3 slti", 32'd0, 1'b0);
    drive(IMM, 3'b011, 7'h7F, 32'd5, 32'hFFFF_FFFD);
    check("R4 sltiu", 32'd1, 1'b0);
    drive(REG, 3'b010, 7'h00, 32'd4, 32'd4);
    check("R3 slt equal", 32'd0, 1'b0);
  endtask

  task automatic t_logic;
    drive(REG, 3'b100, 7'h00, 32'hF0F0_F0F0, 32'hFF00_FF00);
    check("R5 xor", 32'h0FF0_0FF0, 1'b0);
    drive(REG, 3'b110, 7'h00, 32'hF0F0_F0F0, 32'hFF00_FF00);
    check("R5 or", 32'hFFF0_FFF0, 1'b0);
    drive(IMM, 3'b111, 7'h7F, 32'hF0F0_F0F0, 32'hFF00_FF00);
    check("R5 andi", 32'hF000_F000, 1'b0);
  endtask

  task automatic t_shift;
    drive(REG, 3'b001, 7'h00, 32'd1, 32'h0000_0021);
    check("R6 sll uses low five bits", 32'd2, 1'b0);
    drive(IMM, 3'b001, 7'h00, 32'd1, 32'd31);
    check("R6 slli by 31", 32'h8000_0000, 1'b0);
    drive(REG, 3'b101, 7'h00, 32'h8000_0000, 32'd4);
    check("R7 srl", 32'h0800_0000, 1'b0);
    drive(REG, 3'b101, 7'h20, 32'h8000_0000, 32'd4);
    check("R7 sra", 32'hF800_0000, 1'b0);
    drive(IMM, 3'b101, 7'h20, 32'h8000_0000, 32'h0000_0404);
    check("R7 srai", 32'hF800_0000, 1'b0);
    drive(IMM, 3'b101, 7'h20, 32'h4000_0000, 32'h0000_0404);
    check("R7 srai positive", 32'h0400_0000, 1'b0);
  endtask

  task automatic t_upper;
    uimm = 20'h12345;
    drive(LUI, 3'b111, 7'h55, 32'hDEAD_BEEF, 32'hCAFE_F00D);
    check("R8 lui ignores operands", 32'h1234_5000, 1'b0);
    uimm = 20'hFFFFF; pc = 32'h0000_2000;
    drive(AUI, 3'b000, 7'h7F, 32'd0, 32'd0);
    check("R9 auipc wrap", 32'h0000_1000, 1'b0);
  endtask

  task automatic t_illegal;
    drive(REG, 3'b000, 7'h01, 32'd6, 32'd7);
    check("R10 multiply funct7", 32'd0, 1'b1);
    drive(REG, 3'b001, 7'h20, 32'd6, 32'd7);
    check("R10 alt funct7 on sll", 32'd0, 1'b1);
    drive(IMM, 3'b001, 7'h20, 32'd6, 32'd7);
    check("R10 slli bad funct7", 32'd0, 1'b1);
    drive(IMM, 3'b101, 7'h10, 32'd6, 32'd7);
    check("R10 srli bad funct7", 32'd0, 1'b1);
    drive(7'b1100011, 3'b000, 7'h00, 32'd6, 32'd6);
    check("R10 branch opcode", 32'd0, 1'b1);
    drive(REG, 3'b111, 7'h00, 32'd6, 32'd3);
    check("R11 legal after illegal", 32'd2, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_add();
    t_sub();
    t_compare();
    t_logic();
    t_shift();
    t_upper();
    t_illegal();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule